// File: doc/BRIEF.md
# Coupling-Aware Four-Mask Link Codec

This block cuts dynamic power on a network-on-chip link by re-coding each body flit before it goes onto the wires. For every valid payload, the encoder builds four candidate link words by applying one of four fixed masks to the payload: leave it as it is, flip the odd-numbered bits, flip the even-numbered bits, or flip every bit. It scores each candidate against the word currently held on the link, using a weighted count of coupling transitions between neighbouring lines plus the number of lines that toggle. The cheapest candidate is registered onto the link, and two extra lines carry the mask choice.

The decoder sits at the far end of the link. It takes the two code lines, rebuilds the same mask and XORs it back out of the payload. It keeps no history of earlier words. Both ends use a plain valid-qualified interface with no back-pressure. The top module holds one encoder and one decoder, so a bench or an integrator can loop the link back or run it through a longer path.

Top module: `lnk_inv_codec`

## Requirements
- R1: While reset is high and after it falls, the link word is all zeros, `link_valid` is low and `out_valid` is low.
- R2: The link word is `{code[1:0], payload ^ mask}`, with code[1] at bit W+1 and code[0] at bit W. Code 00 means no flip, 10 flips payload bits 1, 3, 5 and so on, 01 flips payload bits 0, 2, 4 and so on, and 11 flips every payload bit.
- R3: A candidate's cost is the number of toggling lines among all W+2 link lines, plus a score for each adjacent payload pair (i, i+1). The pair scores 1 when exactly one of its two lines toggles, 2 when both toggle in opposite directions, and 0 when both toggle the same way or neither toggles.
- R4: The encoder sends the candidate with the lowest cost. Equal costs are resolved in the order none, odd, even, full.
- R5: Costs are measured against the last link word the encoder sent, code bits included. That reference is zero after reset.
- R6: A flit accepted with `in_valid` appears on `link_word` one clock later, with `link_valid` high for exactly that cycle.
- R7: In a cycle without `in_valid`, the link word keeps its previous value, so no line toggles.
- R8: The decoder registers `rx_word[W-1:0] ^ mask(rx_word[W+1:W])` onto `out_data` one clock after `rx_valid`, and raises `out_valid` for that cycle. It holds `out_data` otherwise.
- R9: The cost of the word that is sent never exceeds the cost of sending the payload uninverted with code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload on `in_data` is to be sent |
| in_data | input | W | Raw flit payload |
| link_valid | output | 1 | Encoded word is new this cycle |
| link_word | output | W+2 | Encoded link lines, code on the top two bits |
| rx_valid | input | 1 | Received link word is valid |
| rx_word | input | W+2 | Received link lines |
| out_valid | output | 1 | Decoded payload is valid |
| out_data | output | W | Decoded payload |

## Verification
The embedded properties check four things on every cycle: the one-cycle latency at both ends, that the link lines and decoded data stay frozen while idle, and that the chosen cost never exceeds the cost of the plain word. The scenarios check the rest. Only they show that the chosen mask is the true minimum under the weighted cost, that ties go to the earlier option, that the code bits take part in the history, and that every payload returns unchanged through the decoder. They use a scoreboard fed by an independent cost model, plus directed flits whose cheapest option is each of the full, even, odd and plain masks in turn.

// File: rtl/lnk_inv_pkg.sv
package lnk_inv_pkg;

    localparam int N_CAND = 4;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_EVEN = 2'b01,
        ACT_ODD  = 2'b10,
        ACT_FULL = 2'b11
    } inv_act_e;

    // Candidate rank to action; rank order is the tie-break order.
    function automatic logic [1:0] act_of_rank(input int rank);
        case (rank)
            0:       return ACT_NONE;
            1:       return ACT_ODD;
            2:       return ACT_EVEN;
            default: return ACT_FULL;
        endcase
    endfunction

    // Whether payload bit idx is flipped under a given action code.
    function automatic logic flip_bit(input int idx, input logic [1:0] act);
        return ((idx % 2) == 0) ? act[0] : act[1];
    endfunction

    // Weighted coupling score of one adjacent line pair.
    function automatic logic [1:0] pair_cost(input logic p_lo, input logic p_hi,
                                             input logic n_lo, input logic n_hi);
        logic t_lo;
        logic t_hi;
        t_lo = p_lo ^ n_lo;
        t_hi = p_hi ^ n_hi;
        if (t_lo ^ t_hi)
            return 2'd1;
        else if (t_lo && t_hi && (p_lo ^ p_hi))
            return 2'd2;
        else
            return 2'd0;
    endfunction

endpackage

// File: rtl/lnk_cand_eval.sv
module lnk_cand_eval #(
    parameter int         W   = 32,
    parameter int         CW  = 7,
    parameter logic [1:0] ACT = 2'b00
) (
    input  logic [W+1:0]  prev_word,
    input  logic [W-1:0]  data,
    output logic [W+1:0]  cand_word,
    output logic [CW-1:0] cost
);
    import lnk_inv_pkg::*;

    localparam int LW = W + 2;
    localparam int NP = W - 1;

    logic [W-1:0]  mask;
    logic [LW-1:0] tog;
    logic [1:0]    pc [NP];

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mask[g] = flip_bit(g, ACT);
    end

    assign cand_word = {ACT, data ^ mask};
    assign tog       = prev_word ^ cand_word;

    for (genvar g = 0; g < NP; g++) begin : g_pair
        assign pc[g] = pair_cost(prev_word[g], prev_word[g+1],
                                 cand_word[g], cand_word[g+1]);
    end

    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < LW; i++) acc = acc + CW'(tog[i]);
        for (int i = 0; i < NP; i++) acc = acc + CW'(pc[i]);
        cost = acc;
    end

endmodule

// File: rtl/lnk_min_select.sv
module lnk_min_select #(
    parameter int CW = 7
) (
    input  logic [CW-1:0] cost [lnk_inv_pkg::N_CAND],
    output logic [1:0]    rank,
    output logic [CW-1:0] best
);
    import lnk_inv_pkg::*;

    // Strict comparison keeps the earlier rank on a tie.
    always_comb begin
        rank = 2'd0;
        best = cost[0];
        for (int k = 1; k < N_CAND; k++) begin
            if (cost[k] < best) begin
                rank = 2'(k);
                best = cost[k];
            end
        end
    end

endmodule

// File: rtl/lnk_encoder.sv
module lnk_encoder #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         link_valid,
    output logic [W+1:0] link_word
);
    import lnk_inv_pkg::*;

    localparam int LW = W + 2;
    localparam int CW = $clog2(3 * W + 1);

    logic [LW-1:0] word_q;
    logic          valid_q;
    logic [LW-1:0] cand_word [N_CAND];
    logic [CW-1:0] cand_cost [N_CAND];
    logic [1:0]    sel_rank;
    logic [CW-1:0] sel_cost;

    for (genvar k = 0; k < N_CAND; k++) begin : g_cand
        lnk_cand_eval #(
            .W   (W),
            .CW  (CW),
            .ACT (act_of_rank(k))
        ) u_eval (
            .prev_word (word_q),
            .data      (in_data),
            .cand_word (cand_word[k]),
            .cost      (cand_cost[k])
        );
    end

    lnk_min_select #(.CW(CW)) u_sel (
        .cost (cand_cost),
        .rank (sel_rank),
        .best (sel_cost)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) word_q <= cand_word[sel_rank];
        end
    end

    assign link_word  = word_q;
    assign link_valid = valid_q;

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> link_valid);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !link_valid);
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(link_word));
    a_r9_cost_bound: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> sel_cost <= cand_cost[0]);

endmodule

// File: rtl/lnk_decoder.sv
module lnk_decoder #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_valid,
    input  logic [W+1:0] rx_word,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    import lnk_inv_pkg::*;

    logic [1:0]   code;
    logic [W-1:0] mask;
    logic [W-1:0] data_q;
    logic         valid_q;

    assign code = rx_word[W+1:W];

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mask[g] = flip_bit(g, code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rx_valid;
            if (rx_valid) data_q <= rx_word[W-1:0] ^ mask;
        end
    end

    assign out_data  = data_q;
    assign out_valid = valid_q;

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> out_valid);
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> (!out_valid && $stable(out_data)));

endmodule

// File: rtl/lnk_inv_codec.sv
module lnk_inv_codec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         link_valid,
    output logic [W+1:0] link_word,
    input  logic         rx_valid,
    input  logic [W+1:0] rx_word,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    lnk_encoder #(.W(W)) u_enc (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .link_valid (link_valid),
        .link_word  (link_word)
    );

    lnk_decoder #(.W(W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (!link_valid && !out_valid && link_word == '0));

endmodule

// File: tb/sim_lnk_inv_codec.sv
`timescale 1ns/1ps
module sim_lnk_inv_codec;

    localparam int W  = 32;
    localparam int LW = W + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          link_valid;
    logic [LW-1:0] link_word;
    logic          out_valid;
    logic [W-1:0]  out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit mon_on = 0;

    logic [LW-1:0] drv_prev = '0;
    logic [LW-1:0] mon_prev = '0;
    logic [LW-1:0] q_word [$];
    logic [W-1:0]  q_raw  [$];
    logic [W-1:0]  q_out  [$];

    always #2 clk = ~clk;

    lnk_inv_codec #(.W(W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .link_valid (link_valid),
        .link_word  (link_word),
        .rx_valid   (link_valid),
        .rx_word    (link_word),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Independent cost model from the requirement text.
    function automatic int model_cost(input logic [LW-1:0] p, input logic [LW-1:0] n);
        int c = 0;
        for (int i = 0; i < LW; i++) if (p[i] != n[i]) c++;
        for (int i = 0; i < W - 1; i++) begin
            bit ta = p[i] ^ n[i];
            bit tb = p[i+1] ^ n[i+1];
            if (ta != tb) c += 1;
            else if (ta && tb && (p[i] != p[i+1])) c += 2;
        end
        return c;
    endfunction

    function automatic logic [LW-1:0] model_cand(input logic [W-1:0] d, input int r);
        logic [1:0] code;
        logic [W-1:0] m;
        code = (r == 0) ? 2'b00 : (r == 1) ? 2'b10 : (r == 2) ? 2'b01 : 2'b11;
        for (int i = 0; i < W; i++) m[i] = (i % 2 == 0) ? code[0] : code[1];
        return {code, d ^ m};
    endfunction

    task automatic send(input logic [W-1:0] d);
        logic [LW-1:0] best_w;
        int best_c;
        best_w = model_cand(d, 0);
        best_c = model_cost(drv_prev, best_w);
        for (int r = 1; r < 4; r++) begin
            logic [LW-1:0] cw;
            cw = model_cand(d, r);
            if (model_cost(drv_prev, cw) < best_c) begin
                best_c = model_cost(drv_prev, cw);
                best_w = cw;
            end
        end
        q_word.push_back(best_w);
        q_raw.push_back(d);
        q_out.push_back(d);
        drv_prev = best_w;
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_data  = $urandom;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares outputs against the scoreboard queues.
    always @(negedge clk) begin
        if (mon_on) begin
            if (link_valid) begin
                if (q_word.size() == 0) begin
                    chk(0, "R6", "unexpected link word", 64'(link_word), 64'd0);
                end else begin
                    logic [LW-1:0] ew;
                    logic [W-1:0]  rw;
                    ew = q_word.pop_front();
                    rw = q_raw.pop_front();
                    chk(link_word == ew, "R3/R4", "chosen link word", 64'(link_word), 64'(ew));
                    chk(model_cost(mon_prev, link_word) <= model_cost(mon_prev, {2'b00, rw}),
                        "R9", "cost above plain", 64'(model_cost(mon_prev, link_word)),
                        64'(model_cost(mon_prev, {2'b00, rw})));
                end
                mon_prev = link_word;
            end else begin
                chk(link_word == mon_prev, "R7", "idle link changed", 64'(link_word), 64'(mon_prev));
            end
            if (out_valid) begin
                if (q_out.size() == 0) begin
                    chk(0, "R8", "unexpected decoded flit", 64'(out_data), 64'd0);
                end else begin
                    logic [W-1:0] eo;
                    eo = q_out.pop_front();
                    chk(out_data == eo, "R8", "round trip", 64'(out_data), 64'(eo));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(link_word == '0, "R1", "link word in reset", 64'(link_word), 64'd0);
        chk(!link_valid, "R1", "link_valid in reset", 64'(link_valid), 64'd0);
        chk(!out_valid, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(link_word == '0 && !link_valid, "R1", "after reset", 64'(link_word), 64'd0);
        mon_on = 1;

        // R2/R5 directed: full, even, odd and plain masks win in turn.
        send(32'hFFFF_FFFF); idle(1);
        chk(link_word == {2'b11, 32'h0}, "R2", "full mask", 64'(link_word), 64'({2'b11, 32'h0}));
        send(32'h5555_5555); idle(1);
        chk(link_word == {2'b01, 32'h0}, "R2", "even mask", 64'(link_word), 64'({2'b01, 32'h0}));
        send(32'hAAAA_AAAA); idle(1);
        chk(link_word == {2'b10, 32'h0}, "R2", "odd mask", 64'(link_word), 64'({2'b10, 32'h0}));
        send(32'h0000_0000); idle(1);
        chk(link_word == {2'b00, 32'h0}, "R5", "code lines in history", 64'(link_word), 64'd0);
        idle(2);

        // R6: one-cycle latency, back-to-back flits
        in_valid = 1'b1;
        in_data  = 32'h1234_5678;
        @(posedge clk);
        #1;
        chk(link_valid == 1'b1, "R6", "valid one cycle later", 64'(link_valid), 64'd1);
        @(negedge clk);
        begin
            logic [LW-1:0] w;
            int bc;
            w = model_cand(32'h1234_5678, 0);
            bc = model_cost(drv_prev, w);
            for (int r = 1; r < 4; r++)
                if (model_cost(drv_prev, model_cand(32'h1234_5678, r)) < bc) begin
                    bc = model_cost(drv_prev, model_cand(32'h1234_5678, r));
                    w = model_cand(32'h1234_5678, r);
                end
            q_word.push_back(w);
            q_raw.push_back(32'h1234_5678);
            q_out.push_back(32'h1234_5678);
            drv_prev = w;
        end
        for (int i = 0; i < 20; i++) send($urandom);
        idle(3);

        // R4: sparse patterns close to the previous word provoke ties
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] d;
            d = drv_prev[W-1:0] ^ (32'h1 << ($urandom % W));
            if ($urandom % 2) d = d ^ (32'h1 << ($urandom % W));
            send(d);
            if ($urandom % 4 == 0) idle($urandom % 3 + 1);
        end

        // R3/R9: dense random and alternating patterns
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 4)
                0: send($urandom);
                1: send(32'hAAAA_AAAA ^ (32'h1 << ($urandom % W)));
                2: send(32'h5555_5555 ^ $urandom % 16);
                default: send(~drv_prev[W-1:0]);
            endcase
            if ($urandom % 5 == 0) idle(1);
        end
        idle(4);

        chk(q_word.size() == 0, "R6", "words left unsent", 64'(q_word.size()), 64'd0);
        chk(q_out.size() == 0, "R8", "flits left undecoded", 64'(q_out.size()), 64'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule